// File: doc/BRIEF.md
# Auxiliary-Channel Manchester Request Transmitter

This block turns one request on a display link's auxiliary channel into a Manchester-II coded, half-duplex line signal. A requester presents a command nibble, a 20-bit address, a length byte, a preamble length and a payload of up to sixteen bytes, then strobes `req_i` for one clock. The block captures all of these at that edge. It then drives the coded frame onto `line_o` and holds `oe_o` high so that an external half-duplex driver owns the wire.

The frame is sent in a fixed order. It opens with a run of coded zeros for the receiver to lock on. A sync-end marker follows: two half-bit times high, then two low. This marker breaks the Manchester rule on purpose. Next come the command, the address and the length field, each sent MSB first. Payload bytes follow on write commands only. The same two-high/two-low marker closes the frame.

The half-bit time is a whole number of system clocks (`HALF_DIV`). With a 50 MHz clock and the default of 25, the symbol rate is 1 Mbit/s. When the stop marker ends, `oe_o` falls and `done_o` pulses for one clock.

Top module: `aux_mch_tx`

## Requirements
- R1: Every coded bit spans two half-bit times of `HALF_DIV` clocks each, with opposite levels in the two halves: a 1 is sent high then low, and a 0 is sent low then high. The line changes level only at half-bit boundaries.
- R2: The frame opens with `pre_len_i` coded zeros. Values below 16 are raised to 16 and values above 32 are lowered to 32.
- R3: Straight after the preamble, the line is held high for two half-bit times and then low for two half-bit times.
- R4: After the sync-end marker come the 4-bit command, the 20-bit address and the 8-bit length field, in that order, each MSB first.
- R5: Payload is sent only for write commands. These are command 4'b1000, and any command with bit 3 clear and bits 1:0 equal to 00 (bit 2 is ignored). Read (4'b1001), I2C read (bits 1:0 = 01), write-status request (10) and reserved (11) carry no payload.
- R6: A write sends `len_i`+1 payload bytes, capped at `MAX_BYTES`. Byte k is taken from `data_i[8k+7:8k]`, byte 0 goes first, and each byte is sent MSB first.
- R7: The frame ends with two half-bit times high followed by two low, after which the line stops being driven.
- R8: `oe_o` rises in the clock after the accepting edge and stays high until the stop marker has finished. While `oe_o` is low, `line_o` sits at the neutral level 0.
- R9: `done_o` is high for exactly one clock, the first clock after `oe_o` falls.
- R10: A strobe that arrives while a frame is being sent is ignored. The current frame keeps the fields it captured, and no second frame follows it.
- R11: During and after reset, `oe_o`, `line_o` and `done_o` are all 0. A reset in mid-frame stops driving at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-clock request strobe |
| cmd_i | input | 4 | Command nibble |
| addr_i | input | 20 | Target address |
| len_i | input | 8 | Byte count minus one |
| pre_len_i | input | 6 | Number of preamble zeros (clamped to 16..32) |
| data_i | input | 8*MAX_BYTES | Payload, byte k in bits [8k+7:8k] |
| line_o | output | 1 | Coded line level |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-clock end-of-frame pulse |

## Verification
Half-bit h of a frame drives `line_o` for clocks h*HALF_DIV through h*HALF_DIV+HALF_DIV-1, counted from the first clock after the accepting edge. `done_o` is due in the single clock after the last half-bit. The bench builds each expected half-bit sequence from the request fields. It then compares `line_o` and `oe_o` on the falling edge of every clock in the frame, so a sample never lands on a level change. The check that fails reports the frame field where the first mismatch occurred. The done pulse is sampled on the two falling edges that follow the frame.

// File: rtl/aux_tx_pkg.sv
package aux_tx_pkg;

    localparam int CMD_W    = 4;
    localparam int ADDR_W   = 20;
    localparam int LEN_W    = 8;
    localparam int PRE_W    = 6;
    localparam int HDR_W    = CMD_W + ADDR_W + LEN_W;
    localparam int PRE_MIN  = 16;
    localparam int PRE_MAX  = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SYNC,
        PH_BODY,
        PH_STOP,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } hdr_t;

    // Native write (1000) or I2C-style write (x00 with bit 3 clear).
    function automatic logic cmd_has_payload(input logic [CMD_W-1:0] c);
        if (c[3]) return (c[2:0] == 3'b000);
        else      return (c[1:0] == 2'b00);
    endfunction

    function automatic logic [PRE_W-1:0] pre_clamp(input logic [PRE_W-1:0] p);
        if (int'(p) < PRE_MIN)      return PRE_W'(PRE_MIN);
        else if (int'(p) > PRE_MAX) return PRE_W'(PRE_MAX);
        else                        return p;
    endfunction

endpackage

// File: rtl/aux_half_tick.sv
module aux_half_tick #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (tick_o)   cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);  // R1
        end
    endgenerate

endmodule

// File: rtl/aux_frame_seq.sv
module aux_frame_seq
    import aux_tx_pkg::*;
#(
    parameter int BODY_W = 160,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BODY_W-1:0] body_i,
    input  logic [CNT_W-1:0]  body_bits_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic              tick_i,
    output logic              run_o,
    output logic              level_o,
    output logic              oe_o,
    output logic              done_o
);
    localparam int REM_W = (CNT_W > PRE_W) ? CNT_W : PRE_W;

    phase_e            ph_q;
    logic [1:0]        sub_q;
    logic [REM_W-1:0]  rem_q;
    logic [REM_W-1:0]  body_rem_q;
    logic [BODY_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            sub_q      <= '0;
            rem_q      <= '0;
            body_rem_q <= '0;
            sh_q       <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        ph_q       <= PH_PRE;
                        sub_q      <= '0;
                        rem_q      <= REM_W'(pre_clamp(pre_i)) - 1'b1;
                        body_rem_q <= REM_W'(body_bits_i) - 1'b1;
                        sh_q       <= body_i;
                    end
                end
                PH_PRE: begin
                    if (tick_i) begin
                        if (!sub_q[0]) begin
                            sub_q <= 2'd1;
                        end else begin
                            sub_q <= '0;
                            if (rem_q == '0) ph_q <= PH_SYNC;
                            else             rem_q <= rem_q - 1'b1;
                        end
                    end
                end
                PH_SYNC: begin
                    if (tick_i) begin
                        if (sub_q == 2'd3) begin
                            ph_q  <= PH_BODY;
                            sub_q <= '0;
                            rem_q <= body_rem_q;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                end
                PH_BODY: begin
                    if (tick_i) begin
                        if (!sub_q[0]) begin
                            sub_q <= 2'd1;
                        end else begin
                            sub_q <= '0;
                            sh_q  <= {sh_q[BODY_W-2:0], 1'b0};
                            if (rem_q == '0) ph_q <= PH_STOP;
                            else             rem_q <= rem_q - 1'b1;
                        end
                    end
                end
                PH_STOP: begin
                    if (tick_i) begin
                        if (sub_q == 2'd3) begin
                            ph_q  <= PH_DONE;
                            sub_q <= '0;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        level_o = 1'b0;
        case (ph_q)
            PH_PRE:  level_o = sub_q[0];
            PH_SYNC,
            PH_STOP: level_o = !sub_q[1];
            PH_BODY: level_o = sub_q[0] ? !sh_q[BODY_W-1] : sh_q[BODY_W-1];
            default: level_o = 1'b0;
        endcase
    end

    assign oe_o   = (ph_q == PH_PRE) || (ph_q == PH_SYNC) ||
                    (ph_q == PH_BODY) || (ph_q == PH_STOP);
    assign run_o  = oe_o;
    assign done_o = (ph_q == PH_DONE);

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE && start_i) |=> $stable(body_rem_q));  // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R9
    AST_DONE_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!oe_o && $past(oe_o)));  // R9
    AST_STOP_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_STOP && sub_q == 2'd3 && tick_i) |=> done_o);  // R7

endmodule

// File: rtl/aux_mch_tx.sv
module aux_mch_tx
    import aux_tx_pkg::*;
#(
    parameter int HALF_DIV  = 25,
    parameter int MAX_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_i,
    input  logic [3:0]             cmd_i,
    input  logic [19:0]            addr_i,
    input  logic [7:0]             len_i,
    input  logic [5:0]             pre_len_i,
    input  logic [8*MAX_BYTES-1:0] data_i,
    output logic                   line_o,
    output logic                   oe_o,
    output logic                   done_o
);
    localparam int PAY_W  = 8 * MAX_BYTES;
    localparam int BODY_W = HDR_W + PAY_W;
    localparam int CNT_W  = $clog2(BODY_W + 1);

    hdr_t              hdr;
    logic [PAY_W-1:0]  pay_ord;
    logic [BODY_W-1:0] body;
    logic [CNT_W-1:0]  body_bits;
    logic              half_tick;
    logic              run;
    int                nbytes;
    int                nbits;

    assign hdr.cmd  = cmd_i;
    assign hdr.addr = addr_i;
    assign hdr.len  = len_i;

    // Byte 0 of the payload port goes to the top of the shift image.
    generate
        for (genvar k = 0; k < MAX_BYTES; k++) begin : g_order
            assign pay_ord[PAY_W-1-8*k -: 8] = data_i[8*k +: 8];
        end
    endgenerate

    assign body = {hdr, pay_ord};

    always_comb begin
        nbytes = (int'(len_i) >= MAX_BYTES) ? MAX_BYTES : int'(len_i) + 1;
        nbits  = HDR_W + (cmd_has_payload(cmd_i) ? 8 * nbytes : 0);
    end
    assign body_bits = CNT_W'(nbits);

    aux_half_tick #(.DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (half_tick)
    );

    aux_frame_seq #(.BODY_W(BODY_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (req_i),
        .body_i      (body),
        .body_bits_i (body_bits),
        .pre_i       (pre_len_i),
        .tick_i      (half_tick),
        .run_o       (run),
        .level_o     (line_o),
        .oe_o        (oe_o),
        .done_o      (done_o)
    );

    AST_IDLE_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> !line_o);  // R8
    AST_HALF_STABLE: assert property (@(posedge clk) disable iff (rst)
        (oe_o && $past(oe_o) && !$past(half_tick)) |-> $stable(line_o));  // R1
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!oe_o && !done_o));  // R11

endmodule

// File: tb/sim_aux_mch_tx.sv
module sim_aux_mch_tx;

    localparam int HALF = 25;
    localparam int MAXB = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [3:0]        cmd = '0;
    logic [19:0]       addr = '0;
    logic [7:0]        len = '0;
    logic [5:0]        pre = '0;
    logic [8*MAXB-1:0] data = '0;
    logic              line, oe, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    aux_mch_tx #(.HALF_DIV(HALF), .MAX_BYTES(MAXB)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .cmd_i(cmd), .addr_i(addr),
        .len_i(len), .pre_len_i(pre), .data_i(data),
        .line_o(line), .oe_o(oe), .done_o(done)
    );

    // {pre[5:0], cmd[3:0], len[7:0], addr[19:0]}
    localparam logic [37:0] VEC [0:6] = '{
        {6'd16, 4'h8, 8'd3,   20'h12345},
        {6'd32, 4'h9, 8'd15,  20'hABCDE},
        {6'd20, 4'h4, 8'd0,   20'h00050},
        {6'd10, 4'h5, 8'd2,   20'hF0F0F},
        {6'd40, 4'h0, 8'd200, 20'h80001},
        {6'd17, 4'h2, 8'd5,   20'h33333},
        {6'd24, 4'h8, 8'd15,  20'h7A5C3}
    };

    logic exp_h [0:1023];
    int   reg_h [0:1023];
    int   nh;

    function automatic logic [7:0] pbyte(input int idx, input int k);
        return 8'((k * 37 + idx * 11 + 5) & 255);
    endfunction

    function automatic string reg_req(input int r);
        case (r)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5 R6";
            default: return "R7";
        endcase
    endfunction

    task automatic put_half(input logic b, input int r);
        exp_h[nh] = b; reg_h[nh] = r; nh++;
    endtask

    task automatic put_bit(input logic b, input int r);
        put_half(b, r); put_half(!b, r);
    endtask

    task automatic put_marker(input int r);
        put_half(1'b1, r); put_half(1'b1, r); put_half(1'b0, r); put_half(1'b0, r);
    endtask

    task automatic build_exp(input int idx);
        logic [37:0] v;
        int p, nb;
        bit wr;
        logic [7:0] b;
        v  = VEC[idx];
        nh = 0;
        p  = int'(v[37:32]);
        if (p < 16) p = 16;
        if (p > 32) p = 32;
        for (int i = 0; i < p; i++) put_bit(1'b0, 0);
        put_marker(1);
        for (int i = 3; i >= 0; i--)  put_bit(v[28 + i], 2);
        for (int i = 19; i >= 0; i--) put_bit(v[i], 2);
        for (int i = 7; i >= 0; i--)  put_bit(v[20 + i], 2);
        wr = v[31] ? (v[30:28] == 3'b000) : (v[29:28] == 2'b00);
        nb = (int'(v[27:20]) >= MAXB) ? MAXB : int'(v[27:20]) + 1;
        if (wr) begin
            for (int k = 0; k < nb; k++) begin
                b = pbyte(idx, k);
                for (int i = 7; i >= 0; i--) put_bit(b[i], 3);
            end
        end
        put_marker(4);
    endtask

    task automatic drive_inputs(input int idx);
        logic [37:0] v;
        v    = VEC[idx];
        pre  = v[37:32];
        cmd  = v[31:28];
        len  = v[27:20];
        addr = v[19:0];
        for (int k = 0; k < MAXB; k++) data[8*k +: 8] = pbyte(idx, k);
    endtask

    task automatic report(input bit ok, input string req_s, input string what,
                          input int got, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req_s, what, got, expv);
        end
    endtask

    // Caller has just passed the accepting posedge.
    task automatic check_frame(input int idx);
        int bad_line = 0, bad_oe = 0, first = -1;
        logic got_l = 1'b0;
        for (int h = 0; h < nh; h++) begin
            for (int c = 0; c < HALF; c++) begin
                @(negedge clk);
                req = 1'b0;
                if (line !== exp_h[h]) begin
                    if (first < 0) begin first = h; got_l = line; end
                    bad_line++;
                end
                if (oe !== 1'b1 || done !== 1'b0) bad_oe++;
            end
        end
        if (first >= 0)
            report(1'b0, {"R1 ", reg_req(reg_h[first])},
                   $sformatf("vector %0d line at half %0d", idx, first),
                   int'(got_l), int'(exp_h[first]));
        else
            report(1'b1, "R1", "line trace", 0, 0);
        report(bad_oe == 0, "R8", $sformatf("vector %0d oe held over frame, bad clocks", idx),
               bad_oe, 0);
        @(negedge clk);
        report(oe === 1'b0 && done === 1'b1 && line === 1'b0, "R9",
               $sformatf("vector %0d end {oe,done,line}", idx),
               int'({oe, done, line}), 3'b010);
        @(negedge clk);
        report(done === 1'b0, "R9", $sformatf("vector %0d done width", idx), int'(done), 0);
    endtask

    task automatic launch(input int idx);
        @(negedge clk);
        drive_inputs(idx);
        build_exp(idx);
        req = 1'b1;
        @(posedge clk);
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int quiet_bad;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        report(oe === 1'b0 && line === 1'b0 && done === 1'b0, "R11",
               "outputs in reset", int'({oe, line, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        report(oe === 1'b0 && line === 1'b0 && done === 1'b0, "R11",
               "outputs after reset", int'({oe, line, done}), 0);

        // Table walk: R1-style traces across preamble clamps, command types, lengths
        for (int v = 0; v < 7; v++) begin
            launch(v);
            check_frame(v);
        end

        // R10: strobe with new fields mid-frame is ignored
        launch(0);
        fork
            check_frame(0);
            begin
                repeat (300) @(negedge clk);
                drive_inputs(1);
                req = 1'b1;
                @(negedge clk);
                req = 1'b0;
            end
        join
        quiet_bad = 0;
        for (int c = 0; c < 500; c++) begin
            @(negedge clk);
            if (oe !== 1'b0 || line !== 1'b0) quiet_bad++;
        end
        report(quiet_bad == 0, "R10", "driven clocks after ignored strobe", quiet_bad, 0);

        // R11: reset in mid-frame stops driving
        launch(6);
        repeat (400) @(negedge clk);
        req = 1'b0;
        report(oe === 1'b1, "R8", "oe high mid-frame", int'(oe), 1);
        rst = 1'b1;
        @(negedge clk);
        report(oe === 1'b0 && line === 1'b0 && done === 1'b0, "R11",
               "outputs after mid-frame reset", int'({oe, line, done}), 0);
        rst = 1'b0;
        @(negedge clk);

        // Recovery frame after reset
        launch(2);
        check_frame(2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule